// File: doc/BRIEF.md
# Coherence command packet formatter

This block sits on the memory side of a cache controller. It turns coherence requests into command packets on a flit stream that uses valid/ready flow control. There are four request kinds: multicast invalidate, broadcast invalidate, cleanup and multicast update.

Each request names a target L1 identifier, a data/instruction cache select and a 34-bit line index. An update request also carries a starting word index and a count of data words. The block captures the request and then emits one flit per cycle while the receiver is ready. Each flit carries address, write-data, byte-enable and end-of-packet fields.

The first flit of every packet carries the line index, split across write-data and byte-enable. Multicast packets carry the target identifier in the top address bits, along with type and cache select bits. An update packet adds a word-index flit and then its data words.

Top module: `coh_cmd_fmt`

## Requirements
- R1: The first flit of every packet carries line index bits 31:0 in `flit_wdata_o`, line index bits 33:32 in `flit_be_o[1:0]`, and zeros in `flit_be_o[3:2]`.
- R2: Request kinds 0 (multicast invalidate), 1 (broadcast invalidate) and 2 (cleanup) each produce exactly one flit, with `flit_eop_o` set.
- R3: Kind 3 (multicast update) with N data words produces N+2 flits.
  - Flit 2 carries the zero-extended word index in `flit_wdata_o`.
  - Flits 3 to N+2 carry data words 0 to N-1 in order, where word j is `req_data_i[32*j+31:32*j]`.
  - Every flit after the first has `flit_be_o` = 4'hF.
  - `flit_eop_o` is set on the last flit only.
- R4: For kinds 0 and 3, every flit of the packet carries the same address, built as follows:
  - `flit_addr_o[39:32]` holds the target identifier.
  - Bit 3 is 1 for an update and 0 for an invalidate.
  - Bit 2 is the cache select (0 data, 1 instruction).
  - All other address bits are zero.
- R5: For kinds 1 and 2, `flit_addr_o` is all zeros.
- R6: While `flit_valid_o` is high and `flit_ready_i` is low, the next cycle keeps `flit_valid_o` high and all flit fields unchanged.
- R7: Request acceptance and flit timing:
  - `req_ready_o` is high when no packet is pending, or when the last flit of the pending packet is being transferred in that cycle.
  - It is low during every other flit of a packet.
  - The first flit of an accepted packet is valid in the cycle after acceptance.
- R8: An accepted kind 3 request with N=0 or N>16 raises `err_o` for exactly the cycle after acceptance, and emits no flit.
- R9: After reset, `flit_valid_o` and `err_o` are low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_kind_i | input | 2 | 0 mc invalidate, 1 bc invalidate, 2 cleanup, 3 mc update |
| req_tgt_i | input | 8 | Target L1 identifier |
| req_inst_i | input | 1 | Cache select: 0 data, 1 instruction |
| req_line_i | input | 34 | Cache line index |
| req_widx_i | input | 4 | First word index for updates |
| req_nwords_i | input | 5 | Number of update data words |
| req_data_i | input | 512 | Update data words, word j at bits 32j+31:32j |
| flit_valid_o | output | 1 | Flit valid |
| flit_ready_i | input | 1 | Receiver ready |
| flit_addr_o | output | 40 | Flit address field |
| flit_wdata_o | output | 32 | Flit write-data field |
| flit_be_o | output | 4 | Flit byte-enable field |
| flit_eop_o | output | 1 | Last flit of packet |
| err_o | output | 1 | Rejected update pulse |

## Verification
Two events can fall in the same cycle: the transfer of a packet's last flit, and the acceptance of the next request. The bench provokes this by presenting a new request while it accepts that last flit. It expects `req_ready_o` high in that cycle and the new packet's header one cycle later with no gap.

The bench also presents a request on every non-final flit while the receiver is ready, and expects it to be refused there. A rejected update is judged by `err_o` rising in the following cycle with no flit valid.

// File: rtl/coh_fmt_pkg.sv
`timescale 1ns/1ps
package coh_fmt_pkg;
  typedef enum logic [1:0] {
    K_MC_INVAL  = 2'd0,
    K_BC_INVAL  = 2'd1,
    K_CLEANUP   = 2'd2,
    K_MC_UPDATE = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/coh_addr_gen.sv
`timescale 1ns/1ps
module coh_addr_gen
  import coh_fmt_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int ID_W   = 8
) (
  input  cmd_kind_e          kind_i,
  input  logic [ID_W-1:0]    tgt_i,
  input  logic               inst_i,
  output logic [ADDR_W-1:0]  addr_o
);
  always_comb begin
    addr_o = '0;
    if (kind_i == K_MC_INVAL || kind_i == K_MC_UPDATE) begin
      addr_o[ADDR_W-1 -: ID_W] = tgt_i;
      addr_o[3]                = (kind_i == K_MC_UPDATE);
      addr_o[2]                = inst_i;
    end
  end
endmodule

// File: rtl/coh_word_store.sv
`timescale 1ns/1ps
module coh_word_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [DEPTH*DATA_W-1:0] words_i,
  input  logic [IDX_W-1:0]        rd_idx_i,
  output logic [DATA_W-1:0]       rd_word_o
);
  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     word_q[g] <= '0;
      else if (load_i) word_q[g] <= words_i[g*DATA_W +: DATA_W];
    end
  end

  assign rd_word_o = word_q[rd_idx_i];
endmodule

// File: rtl/coh_flit_seq.sv
`timescale 1ns/1ps
module coh_flit_seq #(
  parameter int CNT_W = 5,
  parameter int NW_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             update_i,
  input  logic [NW_W-1:0]  nwords_i,
  input  logic             flit_ready_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             eop_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q, last_q;
  logic             fire;

  assign fire    = busy_q && flit_ready_i;
  assign valid_o = busy_q;
  assign cnt_o   = cnt_q;
  assign eop_o   = busy_q && (cnt_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (start_i) begin
      // last flit index: header only, or header + index + N words
      busy_q <= 1'b1;
      cnt_q  <= '0;
      last_q <= update_i ? CNT_W'(nwords_i) + CNT_W'(1) : '0;
    end else if (fire) begin
      if (eop_o) busy_q <= 1'b0;
      else       cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/coh_cmd_fmt.sv
`timescale 1ns/1ps
module coh_cmd_fmt
  import coh_fmt_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int DATA_W    = 32,
  parameter int LINE_W    = 34,
  parameter int ID_W      = 8,
  parameter int MAX_WORDS = 16,
  localparam int BE_W  = DATA_W / 8,
  localparam int HI_W  = LINE_W - DATA_W,
  localparam int IDX_W = $clog2(MAX_WORDS),
  localparam int NW_W  = $clog2(MAX_WORDS) + 1,
  localparam int CNT_W = $clog2(MAX_WORDS + 2)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [1:0]                  req_kind_i,
  input  logic [ID_W-1:0]             req_tgt_i,
  input  logic                        req_inst_i,
  input  logic [LINE_W-1:0]           req_line_i,
  input  logic [IDX_W-1:0]            req_widx_i,
  input  logic [NW_W-1:0]             req_nwords_i,
  input  logic [MAX_WORDS*DATA_W-1:0] req_data_i,
  output logic                        flit_valid_o,
  input  logic                        flit_ready_i,
  output logic [ADDR_W-1:0]           flit_addr_o,
  output logic [DATA_W-1:0]           flit_wdata_o,
  output logic [BE_W-1:0]             flit_be_o,
  output logic                        flit_eop_o,
  output logic                        err_o
);
  cmd_kind_e         kind_in, kind_q;
  logic [ID_W-1:0]   tgt_q;
  logic              inst_q;
  logic [LINE_W-1:0] line_q;
  logic [IDX_W-1:0]  widx_q;
  logic              err_q;
  logic              accept, bad_len, start;
  logic [CNT_W-1:0]  cnt, word_sel;
  logic              eop;
  logic [DATA_W-1:0] rd_word;

  assign kind_in     = cmd_kind_e'(req_kind_i);
  assign req_ready_o = !flit_valid_o || (flit_ready_i && eop);
  assign accept      = req_valid_i && req_ready_o;
  assign bad_len     = (kind_in == K_MC_UPDATE) &&
                       (req_nwords_i == '0 || req_nwords_i > NW_W'(MAX_WORDS));
  assign start       = accept && !bad_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= K_MC_INVAL;
      tgt_q  <= '0;
      inst_q <= 1'b0;
      line_q <= '0;
      widx_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept && bad_len;
      if (start) begin
        kind_q <= kind_in;
        tgt_q  <= req_tgt_i;
        inst_q <= req_inst_i;
        line_q <= req_line_i;
        widx_q <= req_widx_i;
      end
    end
  end

  coh_flit_seq #(.CNT_W(CNT_W), .NW_W(NW_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .update_i     (kind_in == K_MC_UPDATE),
    .nwords_i     (req_nwords_i),
    .flit_ready_i (flit_ready_i),
    .valid_o      (flit_valid_o),
    .cnt_o        (cnt),
    .eop_o        (eop)
  );

  assign word_sel = cnt - CNT_W'(2);

  coh_word_store #(.DATA_W(DATA_W), .DEPTH(MAX_WORDS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start),
    .words_i   (req_data_i),
    .rd_idx_i  (word_sel[IDX_W-1:0]),
    .rd_word_o (rd_word)
  );

  coh_addr_gen #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_addr (
    .kind_i (kind_q),
    .tgt_i  (tgt_q),
    .inst_i (inst_q),
    .addr_o (flit_addr_o)
  );

  always_comb begin
    if (cnt == '0) begin
      flit_wdata_o = line_q[DATA_W-1:0];
      flit_be_o    = {{(BE_W-HI_W){1'b0}}, line_q[LINE_W-1:DATA_W]};
    end else if (cnt == CNT_W'(1)) begin
      flit_wdata_o = DATA_W'(widx_q);
      flit_be_o    = '1;
    end else begin
      flit_wdata_o = rd_word;
      flit_be_o    = '1;
    end
  end

  assign flit_eop_o = eop;
  assign err_o      = err_q;
endmodule

// File: rtl/coh_cmd_fmt_chk.sv
`timescale 1ns/1ps
module coh_cmd_fmt_chk #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              flit_valid_o,
  input logic              flit_ready_i,
  input logic [ADDR_W-1:0] flit_addr_o,
  input logic [DATA_W-1:0] flit_wdata_o,
  input logic [BE_W-1:0]   flit_be_o,
  input logic              flit_eop_o,
  input logic              err_o
);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flit_valid_o && !flit_ready_i |=> flit_valid_o && $stable(flit_addr_o) &&
      $stable(flit_wdata_o) && $stable(flit_be_o) && $stable(flit_eop_o));

  p_addr_fixed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flit_valid_o && flit_ready_i && !flit_eop_o |=> flit_valid_o && $stable(flit_addr_o));

  p_multi_update_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flit_valid_o && !flit_eop_o |-> flit_addr_o[3]);

  p_low_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flit_valid_o |-> flit_addr_o[1:0] == 2'b00);

  p_err_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !flit_valid_o);

  p_no_mid_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flit_valid_o && !flit_eop_o |-> !req_ready_o);
endmodule

bind coh_cmd_fmt coh_cmd_fmt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_coh_cmd_fmt.sv
`timescale 1ns/1ps
module sim_coh_cmd_fmt;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [1:0]   req_kind_i = '0;
  logic [7:0]   req_tgt_i = '0;
  logic         req_inst_i = 1'b0;
  logic [33:0]  req_line_i = '0;
  logic [3:0]   req_widx_i = '0;
  logic [4:0]   req_nwords_i = '0;
  logic [511:0] req_data_i = '0;
  logic         flit_valid_o;
  logic         flit_ready_i = 1'b0;
  logic [39:0]  flit_addr_o;
  logic [31:0]  flit_wdata_o;
  logic [3:0]   flit_be_o;
  logic         flit_eop_o;
  logic         err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  coh_cmd_fmt u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_addr(input int kind, input logic [7:0] tgt, input bit inst);
    logic [39:0] a = '0;
    if (kind == 0 || kind == 3) begin
      a[39:32] = tgt;
      a[3]     = (kind == 3);
      a[2]     = inst;
    end
    return a;
  endfunction

  function automatic logic [31:0] word_val(input int seed, input int j);
    return (32'h9E3779B9 * 32'(seed + 1)) ^ (32'h01010101 * 32'(j + 3));
  endfunction

  task automatic run_pkt(input int kind, input logic [7:0] tgt, input bit inst,
                         input logic [33:0] line, input int widx, input int n,
                         input int seed, input bit chain);
    int len;
    bit bad;
    logic [7:0]  tgt2  = ~tgt;
    logic [33:0] line2 = ~line;
    @(negedge clk_i);
    req_kind_i   = 2'(kind);
    req_tgt_i    = tgt;
    req_inst_i   = inst;
    req_line_i   = line;
    req_widx_i   = 4'(widx);
    req_nwords_i = 5'(n);
    for (int j = 0; j < 16; j++) req_data_i[32*j +: 32] = word_val(seed, j);
    req_valid_i = 1'b1;
    #1 chk(req_ready_o == 1'b1, "R7", "idle ready", 64'(req_ready_o), 64'd1);
    @(posedge clk_i); @(negedge clk_i);
    req_valid_i = 1'b0;
    bad = (kind == 3) && (n == 0 || n > 16);
    if (bad) begin
      chk(err_o == 1'b1 && flit_valid_o == 1'b0, "R8", "reject pulse",
          64'({err_o, flit_valid_o}), 64'b10);
      @(negedge clk_i);
      chk(err_o == 1'b0 && flit_valid_o == 1'b0 && req_ready_o == 1'b1, "R8",
          "after reject", 64'({err_o, flit_valid_o, req_ready_o}), 64'b001);
      return;
    end
    len = (kind == 3) ? n + 2 : 1;
    for (int i = 0; i < len; i++) begin
      logic [31:0] ew;
      logic [3:0]  eb;
      flit_ready_i = 1'b0;
      for (int s = 0; s < (seed + i) % 3; s++) begin
        logic [76:0] snap = {flit_addr_o, flit_wdata_o, flit_be_o, flit_eop_o};
        @(posedge clk_i); @(negedge clk_i);
        chk(flit_valid_o && {flit_addr_o, flit_wdata_o, flit_be_o, flit_eop_o} == snap,
            "R6", "stall hold", 64'(flit_wdata_o), snap[36:5]);
      end
      flit_ready_i = 1'b1;
      if (i < len - 1) begin
        req_valid_i = 1'b1;
        #1 chk(req_ready_o == 1'b0, "R7", "mid-packet refuse", 64'(req_ready_o), 64'd0);
        req_valid_i = 1'b0;
      end
      #1;
      ew = (i == 0) ? line[31:0] : (i == 1) ? 32'(widx) : word_val(seed, i - 2);
      eb = (i == 0) ? {2'b00, line[33:32]} : 4'hF;
      chk(flit_valid_o, "R7", "flit valid", 64'(flit_valid_o), 64'd1);
      chk(flit_addr_o == exp_addr(kind, tgt, inst), (kind == 0 || kind == 3) ? "R4" : "R5",
          "addr", 64'(flit_addr_o), 64'(exp_addr(kind, tgt, inst)));
      chk(flit_wdata_o == ew && flit_be_o == eb, (i == 0) ? "R1" : "R3", "wdata/be",
          64'({flit_be_o, flit_wdata_o}), 64'({eb, ew}));
      chk(flit_eop_o == (i == len - 1), (kind == 3) ? "R3" : "R2", "eop",
          64'(flit_eop_o), 64'(i == len - 1));
      if (i == len - 1 && chain) begin
        req_kind_i  = 2'd0;
        req_tgt_i   = tgt2;
        req_inst_i  = ~inst;
        req_line_i  = line2;
        req_valid_i = 1'b1;
        #1 chk(req_ready_o == 1'b1, "R7", "ready on last flit", 64'(req_ready_o), 64'd1);
      end
      @(posedge clk_i); @(negedge clk_i);
      flit_ready_i = 1'b0;
      req_valid_i  = 1'b0;
    end
    if (chain) begin
      #1;
      chk(flit_valid_o && flit_eop_o, "R7", "back-to-back header",
          64'({flit_valid_o, flit_eop_o}), 64'b11);
      chk(flit_addr_o == exp_addr(0, tgt2, ~inst), "R4", "chained addr",
          64'(flit_addr_o), 64'(exp_addr(0, tgt2, ~inst)));
      chk(flit_wdata_o == line2[31:0] && flit_be_o == {2'b00, line2[33:32]}, "R1",
          "chained header", 64'({flit_be_o, flit_wdata_o}), 64'({2'b00, line2[33:32], line2[31:0]}));
      flit_ready_i = 1'b1;
      @(posedge clk_i); @(negedge clk_i);
      flit_ready_i = 1'b0;
    end
    chk(flit_valid_o == 1'b0 && err_o == 1'b0, "R2", "idle after packet",
        64'({flit_valid_o, err_o}), 64'd0);
  endtask

  initial begin
    #2;
    chk(flit_valid_o == 1'b0 && err_o == 1'b0 && req_ready_o == 1'b1, "R9", "in reset",
        64'({flit_valid_o, err_o, req_ready_o}), 64'b001);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(flit_valid_o == 1'b0 && err_o == 1'b0 && req_ready_o == 1'b1, "R9", "after reset",
        64'({flit_valid_o, err_o, req_ready_o}), 64'b001);
    for (int k = 0; k < 3; k++) begin
      for (int v = 0; v < 3; v++) begin
        logic [7:0]  t = (v == 0) ? 8'h00 : (v == 1) ? 8'hFF : 8'hA5;
        logic [33:0] l = (v == 0) ? 34'h0 : (v == 1) ? 34'h3_FFFF_FFFF : 34'h2_1234_5678;
        run_pkt(k, t, v[0], l, 0, 0, k * 3 + v, (v == 2));
      end
    end
    for (int n = 0; n <= 18; n++) begin
      run_pkt(3, 8'(n * 13 + 1), n[0], 34'(64'h1_0000_0000 * 64'(n % 4) + 64'(n * 977)),
              (n * 5) % 16, n, n, (n % 4 == 1));
    end
    run_pkt(3, 8'h5A, 1'b1, 34'h1_DEAD_BEEF, 15, 16, 7, 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule